// File: doc/BRIEF.md
# Two-Output Fast 3-Tap FIR Unit

This block evaluates a 3-tap FIR filter two output positions at a time. Each accepted window carries four consecutive signed input samples, and the unit returns the two filter outputs that the window covers. It uses a minimal-filtering transform in which the two outputs share intermediate products. As a result, each pair of results costs four multiplications where the direct form needs six. A higher-level tiler or line buffer feeds it one window per cycle. The unit runs as a fixed-latency pipeline with no output backpressure.

Filter taps arrive on a separate load strobe. On load, the unit turns them into four filter-side terms and holds them until the next load. Two of those terms are halved sums. The unit keeps them in doubled form, so the halving costs no precision. Each window captures the filter terms that are current when it is accepted, so a tap load never disturbs windows already in the pipeline. The unit keeps every product and sum at full precision. It scales, rounds and saturates back to the sample width only at the output.

Top module: `wino23_unit`

## Requirements
- R1: A window is accepted at a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after the second rising edge that follows the accepting edge, so the accepting edge and two more make three register stages. A new window can be accepted on every edge, and results leave in acceptance order.
- R2: The window carries samples d0..d3, with dk in bits [k*DW +: DW] of `in_win`. The taps are g0..g2, with gk in bits [k*DW +: DW] of `tap_bus`. The full-precision results are y0 = d0·g0 + d1·g1 + d2·g2 and y1 = d1·g0 + d2·g1 + d3·g2, and both are exact before scaling.
- R3: Each output is the full-precision result plus 2^(FRAC−1), shifted arithmetically right by FRAC, which rounds half toward positive infinity. When FRAC is 0 the result passes unchanged. y0 is placed in bits [DW-1:0] of `out_y` and y1 in bits [2*DW-1:DW].
- R4: A high `tap_load` at a rising edge stores `tap_bus` as the new taps. A window accepted at that same edge still uses the previous taps. Windows accepted at later edges use the new taps.
- R5: `in_ready` is low while `rst` is high. It goes high at the first rising edge at which `rst` is sampled low.
- R6: Synchronous reset discards every window in flight, so `out_valid` is low after the reset edge. Reset also clears the taps to zero, so windows accepted before any load produce zero outputs.
- R7: A scaled result above 2^(DW−1)−1 saturates to 2^(DW−1)−1. A scaled result below −2^(DW−1) saturates to −2^(DW−1).
- R8: A window presented with `in_valid` low, or while `in_ready` is low, is ignored and never produces an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input window is valid |
| in_ready | output | 1 | Unit can accept a window |
| in_win | input | 4*DW | Four signed samples, d0 in the low bits |
| tap_load | input | 1 | Store `tap_bus` as the new taps |
| tap_bus | input | 3*DW | Three signed taps, g0 in the low bits |
| out_valid | output | 1 | Output pair is valid |
| out_y | output | 2*DW | Two rounded and saturated results, y0 in the low bits |

## Verification
The bench builds the unit with DW = 6 and FRAC = 3. With these values the full-precision results span about ±3000, so the same windows exercise exact pass-through, the rounding of negative and positive halves, and saturation at both rails. The bench sweeps the extreme tap triples and random tap sets, feeding hundreds of windows under each, and compares every result with the direct 3-tap sum. At small widths this comes close to covering all the sign and carry cases of the shared-product path. Tap loads land in the middle of back-to-back traffic, and resets arrive with windows still in flight.

// File: rtl/wino23_pkg.sv
package wino23_pkg;
   localparam int N_SAMP = 4;   // samples per window
   localparam int N_TAP  = 3;   // filter taps
   localparam int N_PROD = 4;   // shared products per window
   localparam int N_OUT  = 2;   // results per window
endpackage

// File: rtl/wino23_taps.sv
module wino23_taps
   import wino23_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load,
   input  logic [N_TAP*DW-1:0]    taps,
   output logic [N_PROD*(DW+2)-1:0] f_bus
);
   localparam int FW = DW + 2;

   logic signed [FW-1:0] gx [N_TAP];
   logic signed [FW-1:0] nxt [N_PROD];
   logic [N_PROD*FW-1:0] f_q;

   for (genvar k = 0; k < N_TAP; k++) begin : g_ext
      assign gx[k] = {{2{taps[k*DW+DW-1]}}, taps[k*DW +: DW]};
   end

   // Halved terms are kept doubled: the two outer terms are doubled instead.
   always_comb begin
      nxt[0] = gx[0] <<< 1;
      nxt[1] = gx[0] + gx[1] + gx[2];
      nxt[2] = gx[0] - gx[1] + gx[2];
      nxt[3] = gx[2] <<< 1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         f_q <= '0;
      end else if (load) begin
         for (int k = 0; k < N_PROD; k++) f_q[k*FW +: FW] <= nxt[k];
      end
   end

   assign f_bus = f_q;
endmodule

// File: rtl/wino23_pre.sv
module wino23_pre
   import wino23_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      take,
   input  logic [N_SAMP*DW-1:0]      win,
   input  logic [N_PROD*(DW+2)-1:0]  f_in,
   output logic                      v_q,
   output logic [N_PROD*(DW+1)-1:0]  a_bus,
   output logic [N_PROD*(DW+2)-1:0]  f_bus
);
   localparam int AW = DW + 1;

   logic signed [AW-1:0] s [N_SAMP];
   logic signed [AW-1:0] a [N_PROD];

   for (genvar k = 0; k < N_SAMP; k++) begin : g_ext
      assign s[k] = {win[k*DW+DW-1], win[k*DW +: DW]};
   end

   always_comb begin
      a[0] = s[0] - s[2];
      a[1] = s[1] + s[2];
      a[2] = s[2] - s[1];
      a[3] = s[1] - s[3];
   end

   always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else     v_q <= take;
   end

   // Filter terms travel with the window, so later loads cannot reach it.
   always_ff @(posedge clk) begin
      if (take) begin
         for (int k = 0; k < N_PROD; k++) a_bus[k*AW +: AW] <= a[k];
         f_bus <= f_in;
      end
   end
endmodule

// File: rtl/wino23_mul.sv
module wino23_mul
   import wino23_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         v_in,
   input  logic [N_PROD*(DW+1)-1:0]     a_bus,
   input  logic [N_PROD*(DW+2)-1:0]     f_bus,
   output logic                         v_q,
   output logic [N_PROD*(2*DW+3)-1:0]   p_bus
);
   localparam int AW = DW + 1;
   localparam int FW = DW + 2;
   localparam int PW = 2 * DW + 3;

   for (genvar k = 0; k < N_PROD; k++) begin : g_mul
      logic signed [PW-1:0] prod;
      assign prod = $signed(a_bus[k*AW +: AW]) * $signed(f_bus[k*FW +: FW]);
      always_ff @(posedge clk) begin
         if (v_in) p_bus[k*PW +: PW] <= prod;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else     v_q <= v_in;
   end
endmodule

// File: rtl/wino23_post.sv
module wino23_post
   import wino23_pkg::*;
#(
   parameter int DW   = 16,
   parameter int FRAC = 15
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        v_in,
   input  logic [N_PROD*(2*DW+3)-1:0]  p_bus,
   output logic                        v_q,
   output logic [N_OUT*DW-1:0]         y_q
);
   localparam int PW = 2 * DW + 3;
   localparam int SW = PW + 2;

   logic signed [SW-1:0] p   [N_PROD];
   logic signed [SW-1:0] sum [N_OUT];

   for (genvar k = 0; k < N_PROD; k++) begin : g_ext
      assign p[k] = SW'($signed(p_bus[k*PW +: PW]));
   end

   assign sum[0] = p[0] + p[1] + p[2];
   assign sum[1] = p[1] - p[2] - p[3];

   for (genvar l = 0; l < N_OUT; l++) begin : g_lane
      logic signed [SW-1:0] half;
      logic signed [SW-1:0] rnd;
      logic [SW-DW:0]       top;
      logic [DW-1:0]        sat;

      assign half = sum[l] >>> 1;

      if (FRAC == 0) begin : g_pass
         assign rnd = half;
      end else begin : g_round
         localparam logic signed [SW-1:0] BIAS = SW'(1) <<< (FRAC - 1);
         assign rnd = (half + BIAS) >>> FRAC;
      end

      assign top = rnd[SW-1:DW-1];

      always_comb begin
         if ((&top) || !(|top))  sat = rnd[DW-1:0];
         else if (rnd[SW-1])     sat = {1'b1, {(DW-1){1'b0}}};
         else                    sat = {1'b0, {(DW-1){1'b1}}};
      end

      always_ff @(posedge clk) begin
         if (v_in) y_q[l*DW +: DW] <= sat;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else     v_q <= v_in;
   end

   // R2: the shared products always combine to an even doubled result
   a_r2_even_sum: assert property (@(posedge clk) disable iff (rst)
      v_in |-> (sum[0][0] == 1'b0 && sum[1][0] == 1'b0));
endmodule

// File: rtl/wino23_unit.sv
module wino23_unit
   import wino23_pkg::*;
#(
   parameter int DW   = 16,
   parameter int FRAC = 15
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [N_SAMP*DW-1:0]   in_win,
   input  logic                   tap_load,
   input  logic [N_TAP*DW-1:0]    tap_bus,
   output logic                   out_valid,
   output logic [N_OUT*DW-1:0]    out_y
);
   localparam int AW = DW + 1;
   localparam int FW = DW + 2;
   localparam int PW = 2 * DW + 3;

   if (DW < 4 || FRAC < 0 || FRAC >= 2 * DW) begin : g_bad_cfg
      $error("wino23_unit: DW must be >= 4 and FRAC in [0, 2*DW)");
   end

   logic                     ready_q;
   logic                     take;
   logic [N_PROD*FW-1:0]     f_cur;
   logic                     v1, v2;
   logic [N_PROD*AW-1:0]     a1;
   logic [N_PROD*FW-1:0]     f1;
   logic [N_PROD*PW-1:0]     p2;

   always_ff @(posedge clk) ready_q <= !rst;

   assign in_ready = ready_q;
   assign take     = in_valid && ready_q;

   wino23_taps #(.DW(DW)) u_taps (
      .clk(clk), .rst(rst), .load(tap_load), .taps(tap_bus), .f_bus(f_cur));

   wino23_pre #(.DW(DW)) u_pre (
      .clk(clk), .rst(rst), .take(take), .win(in_win), .f_in(f_cur),
      .v_q(v1), .a_bus(a1), .f_bus(f1));

   wino23_mul #(.DW(DW)) u_mul (
      .clk(clk), .rst(rst), .v_in(v1), .a_bus(a1), .f_bus(f1),
      .v_q(v2), .p_bus(p2));

   wino23_post #(.DW(DW), .FRAC(FRAC)) u_post (
      .clk(clk), .rst(rst), .v_in(v2), .p_bus(p2),
      .v_q(out_valid), .y_q(out_y));

   a_r1_latency: assert property (@(posedge clk) disable iff (rst)
      $past(in_valid && in_ready, 2) |=> out_valid);

   a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !$past(in_valid && in_ready, 2) |=> !out_valid);

   a_r6_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid);

   a_r5_ready_low_in_reset: assert property (@(posedge clk)
      $past(rst) |-> !in_ready);
endmodule

// File: tb/wino23_unit_test.sv
module wino23_unit_test;
   localparam int DW   = 6;
   localparam int FRAC = 3;
   localparam int YMAX = (1 << (DW - 1)) - 1;
   localparam int YMIN = -(1 << (DW - 1));

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [4*DW-1:0]   in_win = '0;
   logic              tap_load = 1'b0;
   logic [3*DW-1:0]   tap_bus = '0;
   logic              out_valid;
   logic [2*DW-1:0]   out_y;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;

   int cur_g [3];
   logic pv [3];
   int   py0 [3];
   int   py1 [3];
   string ptag [3];
   logic [31:0] lfsr = 32'h1234_5678;

   always #5 clk = ~clk;

   wino23_unit #(.DW(DW), .FRAC(FRAC)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_win(in_win), .tap_load(tap_load), .tap_bus(tap_bus),
      .out_valid(out_valid), .out_y(out_y));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         tests = tests + 1;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   function automatic int scale(input int full);
      int r;
      r = (FRAC == 0) ? full : ((full + (1 << (FRAC - 1))) >>> FRAC);
      if (r > YMAX) r = YMAX;
      if (r < YMIN) r = YMIN;
      return r;
   endfunction

   function automatic int sx(input logic [DW-1:0] v);
      return int'($signed(v));
   endfunction

   function automatic logic [DW-1:0] rnd6();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return lfsr[DW-1:0] ^ lfsr[DW+7:8];
   endfunction

   task automatic check(input logic ok, input string tag, input string what,
                        input int act, input int exp);
      tests = tests + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Drive at a falling edge, advance one cycle, then check the window driven three cycles back.
   task automatic step(input logic v, input logic [4*DW-1:0] w, input logic ld,
                       input logic [3*DW-1:0] t, input string tag);
      int d [4];
      logic acc;
      in_valid = v; in_win = w; tap_load = ld; tap_bus = t;
      acc = v && in_ready && !rst;
      for (int k = 0; k < 4; k++) d[k] = sx(w[k*DW +: DW]);
      pv[2] = pv[1]; py0[2] = py0[1]; py1[2] = py1[1]; ptag[2] = ptag[1];
      pv[1] = pv[0]; py0[1] = py0[0]; py1[1] = py1[0]; ptag[1] = ptag[0];
      pv[0] = acc;
      py0[0] = scale(d[0]*cur_g[0] + d[1]*cur_g[1] + d[2]*cur_g[2]);
      py1[0] = scale(d[1]*cur_g[0] + d[2]*cur_g[1] + d[3]*cur_g[2]);
      ptag[0] = tag;
      if (ld && !rst) for (int k = 0; k < 3; k++) cur_g[k] = sx(t[k*DW +: DW]);
      @(negedge clk);
      check(out_valid == pv[2], ptag[2], "out_valid", int'(out_valid), int'(pv[2]));
      if (pv[2] && out_valid) begin
         check(sx(out_y[DW-1:0]) == py0[2], ptag[2], "y0", sx(out_y[DW-1:0]), py0[2]);
         check(sx(out_y[2*DW-1:DW]) == py1[2], ptag[2], "y1", sx(out_y[2*DW-1:DW]), py1[2]);
      end
   endtask

   task automatic do_reset(input logic feed);
      rst = 1'b1;
      in_valid = feed; in_win = {4{6'sd9}}; tap_load = 1'b0;
      for (int k = 0; k < 3; k++) begin
         pv[k] = 1'b0; cur_g[k] = 0;
      end
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         // R5, R6: no readiness and no output while reset is held
         check(in_ready == 1'b0, "R5", "in_ready in reset", int'(in_ready), 0);
         check(out_valid == 1'b0, "R6", "out_valid in reset", int'(out_valid), 0);
      end
      in_valid = 1'b0;
      rst = 1'b0;
   endtask

   function automatic logic [4*DW-1:0] mkwin(input int a, input int b, input int c, input int e);
      return {DW'(e), DW'(c), DW'(b), DW'(a)};
   endfunction

   function automatic logic [3*DW-1:0] mktap(input int a, input int b, input int c);
      return {DW'(c), DW'(b), DW'(a)};
   endfunction

   initial begin
      for (int k = 0; k < 3; k++) begin
         pv[k] = 1'b0; py0[k] = 0; py1[k] = 0; ptag[k] = "R1"; cur_g[k] = 0;
      end
      @(negedge clk);
      do_reset(1'b1);   // R8: windows offered during reset are dropped
      step(1'b1, mkwin(5, 6, 7, 8), 1'b0, '0, "R8");  // in_ready still low here
      check(in_ready == 1'b1, "R5", "in_ready after reset", int'(in_ready), 1);

      // R6: zero taps after reset give zero outputs
      step(1'b1, mkwin(31, -32, 17, -5), 1'b0, '0, "R6");
      step(1'b1, mkwin(-7, 3, 30, 12), 1'b0, '0, "R6");

      // R4: load coincides with an accepted window, which keeps the old taps
      step(1'b1, mkwin(8, 8, 8, 8), 1'b1, mktap(1, 0, 0), "R4");
      step(1'b1, mkwin(4, -4, 0, 0), 1'b0, '0, "R4");
      // R3: rounding of halves: 4 -> 1, -4 -> 0, -5 -> -1, 3 -> 0
      step(1'b1, mkwin(-5, 3, 0, 0), 1'b0, '0, "R3");
      step(1'b1, mkwin(12, -12, 0, 0), 1'b0, '0, "R3");
      // R8: gaps without valid
      step(1'b0, mkwin(31, 31, 31, 31), 1'b0, '0, "R8");
      step(1'b0, mkwin(1, 2, 3, 4), 1'b0, '0, "R8");

      // R7: saturation at both rails
      step(1'b1, mkwin(0, 0, 0, 0), 1'b1, mktap(31, 31, 31), "R7");
      step(1'b1, mkwin(31, 31, 31, 31), 1'b0, '0, "R7");
      step(1'b1, mkwin(-32, -32, -32, -32), 1'b0, '0, "R7");
      step(1'b1, mkwin(-32, -32, -32, -32), 1'b1, mktap(-32, -32, -32), "R7");
      step(1'b1, mkwin(-32, -32, -32, -32), 1'b0, '0, "R7");
      step(1'b1, mkwin(31, 31, 31, 31), 1'b0, '0, "R7");

      // R2, R3, R1: sweep tap sets, back-to-back windows with occasional gaps and loads
      for (int s = 0; s < 40; s++) begin
         logic [3*DW-1:0] t;
         case (s)
            0: t = mktap(-32, 31, -32);
            1: t = mktap(31, -32, 31);
            2: t = mktap(0, 0, 1);
            3: t = mktap(0, -1, 0);
            default: t = {rnd6(), rnd6(), rnd6()};
         endcase
         step(1'b1, {rnd6(), rnd6(), rnd6(), rnd6()}, 1'b1, t, "R4");
         for (int i = 0; i < 300; i++) begin
            logic v;
            v = (lfsr[3:0] != 4'd0);
            step(v, {rnd6(), rnd6(), rnd6(), rnd6()}, 1'b0, '0, v ? "R2" : "R8");
         end
      end

      // R6: reset with windows in flight discards them and clears the taps
      step(1'b1, mkwin(10, 11, 12, 13), 1'b1, mktap(3, -2, 5), "R1");
      step(1'b1, mkwin(-9, 4, 20, -1), 1'b0, '0, "R1");
      do_reset(1'b1);
      step(1'b1, mkwin(1, 1, 1, 1), 1'b0, '0, "R5");
      step(1'b1, mkwin(25, -13, 7, 2), 1'b0, '0, "R6");
      step(1'b1, mkwin(3, 3, 3, 3), 1'b1, mktap(2, 2, 2), "R6");
      step(1'b1, mkwin(3, 3, 3, 3), 1'b0, '0, "R2");
      for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, '0, "R1");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule